// File: doc/BRIEF.md
# Segment Address Translator

The block turns a two-part logical address, made of a segment number and an offset, into a flat linear address. It holds a small on-chip table of segment descriptors, each with a start address, a length, a present flag and a set of access permissions, plus a count register that says how many segments are in use. Software fills the descriptor table and the count register through simple write strobes.

A lookup is presented with a request strobe, together with the access kind: read, write or instruction fetch. One clock later the block returns either the start address plus the offset, or a trap carrying a cause code. The cause code names the first check that failed. The checks run in a fixed order: segment number against the count, then the present flag, then the offset against the length, then the permission.

Top module: `seg_xlate`

## Requirements
- R1: While rst_ni is low, rsp_valid_o is 0. Reset clears every descriptor's present flag and sets the segment count to 0, so any lookup after reset, before software writes, traps with cause 1.
- R2: rsp_valid_o is 1 exactly in the cycle after a cycle with req_valid_i high, and 0 otherwise. When rsp_valid_o is 0, rsp_trap_o is 0.
- R3: A segment number greater than or equal to the segment count, or greater than or equal to NUM_SEG, gives a trap with cause 1.
- R4: A descriptor whose present flag is 0 gives a trap with cause 2.
- R5: An offset greater than or equal to the descriptor length gives a trap with cause 3. A length of 0 makes every offset trap.
- R6: Permission bits are bit 0 read, bit 1 write and bit 2 fetch. Access kind 0 is read, 1 is write, 2 is fetch, and 3 always fails. An access whose permission bit is 0 gives a trap with cause 4.
- R7: When several checks fail at once, the cause is the first failing check in the order 1, 2, 3, 4.
- R8: A lookup that passes every check returns rsp_trap_o = 0, rsp_cause_o = 0 and rsp_addr_o = base + offset, taken modulo 2^32.
- R9: A trapping response has rsp_addr_o = 0 and rsp_trap_o = 1.
- R10: A descriptor write or a count write takes effect from the following cycle. A lookup in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Descriptor write strobe |
| tbl_idx_i | input | 4 | Descriptor index to write |
| tbl_base_i | input | 32 | Start address to write |
| tbl_limit_i | input | 20 | Segment length to write |
| tbl_present_i | input | 1 | Present flag to write |
| tbl_perm_i | input | 3 | Permissions to write: bit 0 read, bit 1 write, bit 2 fetch |
| len_we_i | input | 1 | Segment count write strobe |
| len_i | input | 5 | New segment count |
| req_valid_i | input | 1 | Lookup request strobe |
| req_seg_i | input | 4 | Segment number |
| req_off_i | input | 20 | Offset |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| rsp_valid_o | output | 1 | Response strobe, one cycle after the request |
| rsp_addr_o | output | 32 | Linear address, 0 on a trap |
| rsp_trap_o | output | 1 | Lookup failed |
| rsp_cause_o | output | 3 | 0 for success, otherwise the first failing check (1 to 4) |

## Verification
Two things can happen in the same cycle: a lookup, and a descriptor or count write aimed at the segment being looked up. The bench drives both together on purpose, in a directed case and in a random loop that issues writes alongside lookups. In every such cycle the response must match the old descriptor, and the next lookup must match the new one. A behavioural model in the bench applies the writes only after it has judged the lookup of that cycle, and every response is compared with that model.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_BAD_SEG = 3'd1,
    CAUSE_ABSENT  = 3'd2,
    CAUSE_LIMIT   = 3'd3,
    CAUSE_PERM    = 3'd4
  } cause_e;

  localparam int unsigned PERM_W = 3;
endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned LIMIT_W = 20,
  parameter int unsigned PERM_W  = 3,
  localparam int unsigned SEG_W  = $clog2(NUM_SEG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [SEG_W-1:0]   wr_idx_i,
  input  logic [BASE_W-1:0]  wr_base_i,
  input  logic [LIMIT_W-1:0] wr_limit_i,
  input  logic               wr_present_i,
  input  logic [PERM_W-1:0]  wr_perm_i,
  input  logic [SEG_W-1:0]   rd_idx_i,
  output logic [BASE_W-1:0]  rd_base_o,
  output logic [LIMIT_W-1:0] rd_limit_o,
  output logic               rd_present_o,
  output logic [PERM_W-1:0]  rd_perm_o
);
  logic [BASE_W-1:0]  base_q    [NUM_SEG];
  logic [LIMIT_W-1:0] limit_q   [NUM_SEG];
  logic               present_q [NUM_SEG];
  logic [PERM_W-1:0]  perm_q    [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (32'(wr_idx_i) == g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[g]    <= '0;
        limit_q[g]   <= '0;
        present_q[g] <= 1'b0;
        perm_q[g]    <= '0;
      end else if (hit) begin
        base_q[g]    <= wr_base_i;
        limit_q[g]   <= wr_limit_i;
        present_q[g] <= wr_present_i;
        perm_q[g]    <= wr_perm_i;
      end
    end
  end

  // Indices at or above NUM_SEG read as absent; the checker traps them earlier anyway
  always_comb begin
    rd_base_o    = '0;
    rd_limit_o   = '0;
    rd_present_o = 1'b0;
    rd_perm_o    = '0;
    if (32'(rd_idx_i) < NUM_SEG) begin
      rd_base_o    = base_q[rd_idx_i];
      rd_limit_o   = limit_q[rd_idx_i];
      rd_present_o = present_q[rd_idx_i];
      rd_perm_o    = perm_q[rd_idx_i];
    end
  end

  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (base_q[$past(wr_idx_i)] == $past(wr_base_i)) &&
             (limit_q[$past(wr_idx_i)] == $past(wr_limit_i)) &&
             (present_q[$past(wr_idx_i)] == $past(wr_present_i)));
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned LIMIT_W = 20,
  parameter int unsigned OFF_W   = 20,
  localparam int unsigned SEG_W  = $clog2(NUM_SEG),
  localparam int unsigned LEN_W  = $clog2(NUM_SEG + 1),
  localparam int unsigned CMP_W  = (LIMIT_W > OFF_W) ? LIMIT_W : OFF_W
) (
  input  logic [SEG_W-1:0]   seg_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [OFF_W-1:0]   off_i,
  input  acc_e               acc_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               present_i,
  input  logic [PERM_W-1:0]  perm_i,
  output cause_e             cause_o
);
  logic [CMP_W-1:0] off_ext, lim_ext;
  logic seg_bad, over_lim, perm_bad;

  assign off_ext  = CMP_W'(off_i);
  assign lim_ext  = CMP_W'(limit_i);
  assign seg_bad  = (32'(seg_i) >= 32'(len_i)) || (32'(seg_i) >= NUM_SEG);
  assign over_lim = off_ext >= lim_ext;

  always_comb begin
    unique case (acc_i)
      ACC_READ:  perm_bad = !perm_i[0];
      ACC_WRITE: perm_bad = !perm_i[1];
      ACC_FETCH: perm_bad = !perm_i[2];
      default:   perm_bad = 1'b1;
    endcase
  end

  // Fixed priority: the first failing check wins
  always_comb begin
    if (seg_bad)         cause_o = CAUSE_BAD_SEG;
    else if (!present_i) cause_o = CAUSE_ABSENT;
    else if (over_lim)   cause_o = CAUSE_LIMIT;
    else if (perm_bad)   cause_o = CAUSE_PERM;
    else                 cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 16,
  parameter int unsigned BASE_W  = 32,
  parameter int unsigned LIMIT_W = 20,
  parameter int unsigned OFF_W   = 20,
  localparam int unsigned SEG_W  = $clog2(NUM_SEG),
  localparam int unsigned LEN_W  = $clog2(NUM_SEG + 1),
  localparam int unsigned LIN_W  = BASE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tbl_we_i,
  input  logic [SEG_W-1:0]   tbl_idx_i,
  input  logic [BASE_W-1:0]  tbl_base_i,
  input  logic [LIMIT_W-1:0] tbl_limit_i,
  input  logic               tbl_present_i,
  input  logic [2:0]         tbl_perm_i,
  input  logic               len_we_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               req_valid_i,
  input  logic [SEG_W-1:0]   req_seg_i,
  input  logic [OFF_W-1:0]   req_off_i,
  input  logic [1:0]         req_acc_i,
  output logic               rsp_valid_o,
  output logic [LIN_W-1:0]   rsp_addr_o,
  output logic               rsp_trap_o,
  output logic [2:0]         rsp_cause_o
);
  logic [LEN_W-1:0]   len_q;
  logic [BASE_W-1:0]  ent_base;
  logic [LIMIT_W-1:0] ent_limit;
  logic               ent_present;
  logic [PERM_W-1:0]  ent_perm;
  cause_e             cause_d;
  logic [LIN_W-1:0]   sum_d;

  logic               vld_q;
  logic [LIN_W-1:0]   addr_q;
  cause_e             cause_q;

  seg_table #(
    .NUM_SEG(NUM_SEG), .BASE_W(BASE_W), .LIMIT_W(LIMIT_W), .PERM_W(PERM_W)
  ) u_table (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (tbl_we_i),
    .wr_idx_i     (tbl_idx_i),
    .wr_base_i    (tbl_base_i),
    .wr_limit_i   (tbl_limit_i),
    .wr_present_i (tbl_present_i),
    .wr_perm_i    (tbl_perm_i),
    .rd_idx_i     (req_seg_i),
    .rd_base_o    (ent_base),
    .rd_limit_o   (ent_limit),
    .rd_present_o (ent_present),
    .rd_perm_o    (ent_perm)
  );

  seg_check #(
    .NUM_SEG(NUM_SEG), .LIMIT_W(LIMIT_W), .OFF_W(OFF_W)
  ) u_check (
    .seg_i     (req_seg_i),
    .len_i     (len_q),
    .off_i     (req_off_i),
    .acc_i     (acc_e'(req_acc_i)),
    .limit_i   (ent_limit),
    .present_i (ent_present),
    .perm_i    (ent_perm),
    .cause_o   (cause_d)
  );

  assign sum_d = LIN_W'(ent_base) + LIN_W'(req_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       len_q <= '0;
    else if (len_we_i) len_q <= len_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      addr_q  <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      vld_q <= req_valid_i;
      if (req_valid_i) begin
        cause_q <= cause_d;
        addr_q  <= (cause_d == CAUSE_NONE) ? sum_d : '0;
      end else begin
        cause_q <= CAUSE_NONE;
        addr_q  <= '0;
      end
    end
  end

  assign rsp_valid_o = vld_q;
  assign rsp_addr_o  = addr_q;
  assign rsp_cause_o = cause_q;
  assign rsp_trap_o  = vld_q && (cause_q != CAUSE_NONE);

  p_rsp_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  p_rsp_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o && !rsp_trap_o);
  p_bad_seg_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (32'(req_seg_i) >= 32'(len_q))) |=> rsp_cause_o == 3'd1);
  p_absent_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (32'(req_seg_i) < 32'(len_q)) && !ent_present) |=> rsp_cause_o == 3'd2);
  p_trap_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_trap_o) |-> rsp_addr_o == '0);
  p_len_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_we_i |=> len_q == $past(len_i));
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tbl_we_i = 0;
  logic [3:0]  tbl_idx_i = 0;
  logic [31:0] tbl_base_i = 0;
  logic [19:0] tbl_limit_i = 0;
  logic        tbl_present_i = 0;
  logic [2:0]  tbl_perm_i = 0;
  logic        len_we_i = 0;
  logic [4:0]  len_i = 0;
  logic        req_valid_i = 0;
  logic [3:0]  req_seg_i = 0;
  logic [19:0] req_off_i = 0;
  logic [1:0]  req_acc_i = 0;
  logic        rsp_valid_o;
  logic [31:0] rsp_addr_o;
  logic        rsp_trap_o;
  logic [2:0]  rsp_cause_o;

  always #2.5 clk_i = ~clk_i;

  seg_xlate u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  longint m_base [16];
  int     m_limit[16];
  bit     m_pres [16];
  int     m_perm [16];
  int     m_len;
  bit     e_valid;
  longint e_addr;
  int     e_cause;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ref_cause(int seg, int off, int acc);
    if (seg >= m_len || seg >= 16) return 1;
    if (!m_pres[seg]) return 2;
    if (off >= m_limit[seg]) return 3;
    if (acc == 3 || !m_perm[seg][acc]) return 4;
    return 0;
  endfunction

  function automatic string tag_of(int c);
    case (c)
      0: return "R8";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      default: return "R6";
    endcase
  endfunction

  // model: judge this cycle's lookup with old state, then apply writes (R10)
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 16; i++) begin
        m_base[i] = 0; m_limit[i] = 0; m_pres[i] = 0; m_perm[i] = 0;
      end
      m_len = 0; e_valid = 0; e_addr = 0; e_cause = 0;
    end else begin
      e_valid = req_valid_i;
      if (req_valid_i) begin
        e_cause = ref_cause(req_seg_i, req_off_i, req_acc_i);
        e_addr  = (e_cause == 0) ? ((m_base[req_seg_i] + req_off_i) & 64'hFFFF_FFFF) : 0;
      end
      if (tbl_we_i) begin
        m_base[tbl_idx_i]  = tbl_base_i;
        m_limit[tbl_idx_i] = tbl_limit_i;
        m_pres[tbl_idx_i]  = tbl_present_i;
        m_perm[tbl_idx_i]  = tbl_perm_i;
      end
      if (len_we_i) m_len = len_i;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R2 valid", rsp_valid_o, e_valid);
      if (e_valid) begin
        chk({tag_of(e_cause), " cause"}, rsp_cause_o, e_cause);
        chk({(e_cause != 0) ? "R9" : "R8", " trap"}, rsp_trap_o, e_cause != 0);
        chk({(e_cause != 0) ? "R9" : "R8", " addr"}, rsp_addr_o, e_addr);
      end else begin
        chk("R2 idle trap", rsp_trap_o, 0);
      end
    end
  end

  task automatic idle();
    tbl_we_i = 0; len_we_i = 0; req_valid_i = 0;
  endtask

  task automatic put_ent(int idx, longint base, int lim, bit pres, int perm);
    tbl_we_i = 1; tbl_idx_i = 4'(idx); tbl_base_i = 32'(base);
    tbl_limit_i = 20'(lim); tbl_present_i = pres; tbl_perm_i = 3'(perm);
  endtask

  task automatic put_req(int seg, int off, int acc);
    req_valid_i = 1; req_seg_i = 4'(seg); req_off_i = 20'(off); req_acc_i = 2'(acc);
  endtask

  task automatic step();
    @(negedge clk_i);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset valid", rsp_valid_o, 0);
    chk("R1 reset trap", rsp_trap_o, 0);
    rst_ni = 1;
    step();
    // R1: count is 0 after reset
    put_req(0, 0, 0); step();
    chk("R1 lookup after reset", rsp_cause_o, 1);

    len_we_i = 1; len_i = 5'd8; step();
    put_ent(0, 32'h1000_0000, 20'h100, 1, 3'b111); step();
    put_ent(1, 32'hFFFF_FFF0, 20'h40, 1, 3'b001); step();
    put_ent(2, 32'h0000_2000, 0, 1, 3'b111); step();
    put_ent(3, 32'h0000_3000, 20'h10, 0, 3'b111); step();
    put_ent(8, 32'h0008_0000, 20'hFFFFF, 1, 3'b111); step();

    put_req(0, 20'hFF, 0); step();
    chk("R8 offset at limit-1", rsp_addr_o, 32'h1000_00FF);
    put_req(0, 20'h100, 0); step();
    chk("R5 offset at limit", rsp_cause_o, 3);
    put_req(2, 0, 0); step();
    chk("R5 zero length", rsp_cause_o, 3);
    put_req(1, 20'h20, 0); step();
    chk("R8 wraparound", rsp_addr_o, 32'h0000_0010);
    put_req(1, 0, 1); step();
    chk("R6 write denied", rsp_cause_o, 4);
    put_req(0, 0, 3); step();
    chk("R6 reserved access", rsp_cause_o, 4);
    put_req(8, 0, 0); step();
    chk("R3 present entry beyond count", rsp_cause_o, 1);
    // R7 priority cases
    put_req(3, 20'hFFFFF, 3); step();
    chk("R7 absent beats limit", rsp_cause_o, 2);
    put_req(1, 20'hFFFFF, 2); step();
    chk("R7 limit beats perm", rsp_cause_o, 3);
    put_req(9, 0, 3); step();
    chk("R7 bad seg first", rsp_cause_o, 1);
    chk("R9 trap addr zero", rsp_addr_o, 0);
    // R10: write and lookup in the same cycle
    put_ent(3, 32'h0000_5000, 20'h10, 1, 3'b001); put_req(3, 4, 0); step();
    chk("R10 same-cycle old entry", rsp_cause_o, 2);
    put_req(3, 4, 0); step();
    chk("R10 next-cycle new entry", rsp_addr_o, 32'h0000_5004);
    len_we_i = 1; len_i = 5'd16; put_req(8, 0, 0); step();
    chk("R10 old count", rsp_cause_o, 1);
    put_req(8, 5, 2); step();
    chk("R10 new count", rsp_addr_o, 32'h0008_0005);

    // random mixed traffic with writes colliding with lookups
    for (int n = 0; n < 3000; n++) begin
      int s, r, o;
      s = $urandom_range(0, 15);
      r = $urandom_range(0, 2);
      o = (r == 0) ? m_limit[s] : (r == 1) ? m_limit[s] - 1 : $urandom_range(0, 20'hFFFFF);
      if ($urandom_range(0, 3) != 0) put_req(s, o & 20'hFFFFF, $urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0)
        put_ent($urandom_range(0, 15), {$urandom}, $urandom_range(0, 300),
                $urandom_range(0, 5) != 0, $urandom_range(0, 7));
      if ($urandom_range(0, 40) == 0) begin
        len_we_i = 1; len_i = 5'($urandom_range(0, 16));
      end
      step();
    end
    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule